// File: doc/BRIEF.md
# Prescaled Countdown Timer

A 32-bit down-counter advanced by an external base tick through a power-of-two prescaler. Software loads a start value, chooses one-shot or periodic operation and an 8-bit vector, and the block emits a one-cycle interrupt request carrying that vector whenever the count expires and the timer is not masked. The prescaler ratio is chosen by a 3-bit code that is scattered over a 4-bit divide register.

The register port is a plain write strobe with an address and data, plus a combinational read path. Address 0 is the control word, address 1 the start value, address 2 the live count (read only) and address 3 the divide setting. The base tick is a one-cycle enable on the block clock. A synchroniser inside the block releases the asynchronous reset on a clock edge.

Top module: `prog_div_timer`

## Requirements
- R1: The divide register keeps only its bits 0, 1 and 3. Bit 2 and bits 31:4 always read as 0, whatever value was written.
- R2: The divide code is {bit3, bit1, bit0}, with bit 3 as the most significant bit. The prescaler shift is (code + 1) mod 8, and the count moves once every 2^shift base ticks. Code 7 moves it on every tick and code 6 on every 128th tick.
- R3: A write to address 1 loads the start value into the count, clears the prescaler phase and clears the finished state of a one-shot. A tick that arrives in the cycle of that write is not counted.
- R4: In one-shot mode (control bit 17 = 0) the count falls to 0 and stays there. The single expiry happens on the first divided tick seen at 0, which is start + 1 divided ticks after the load.
- R5: In periodic mode (control bit 17 = 1), a divided tick at count 0 reloads the start value and expires. This gives one expiry every start + 1 divided ticks.
- R6: The control word holds the vector in bits 7:0, a mask in bit 16 and the mode in bit 17, and its other bits read as 0. An expiry drives irq_valid high for exactly one cycle, on the clock after the expiry tick, with irq_vector set to the vector, and only when the mask was 0. An expiry that occurs while the mask is 1 is dropped.
- R7: A control write takes effect on the next divided tick. Switching a finished one-shot to periodic resumes expiries and reloads from the count of 0.
- R8: After reset the control word reads 0x00010000, the count, the start value and the divide register read 0, and irq_valid is low.
- R9: A start value of 0 gives no expiry in either mode, and the count reads 0.
- R10: Reads have no side effects. A write to address 2 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_tick | input | 1 | One-cycle base tick enable |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 start, 2 count, 3 divide) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| irq_valid | output | 1 | One-cycle interrupt request |
| irq_vector | output | 8 | Vector carried with irq_valid |

## Verification
The assertions check on every cycle that the count only steps down by one, reloads the start value or takes a loaded value. They also check that a request never follows a masked expiry, that requests never come on two cycles in a row, that a one-shot holds at 0 after expiring, and that code 7 divides by one. Only the bench scenarios can show the exact expiry counts over whole periods, the 128-tick divide, the phase restart on a reload, and the effect of mode switching, register masking and ignored writes. These are compared cycle by cycle against a reference model computed in the bench.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int DATA_W     = 32;
  localparam int VEC_W      = 8;
  localparam int DIV_CODE_W = 3;
  localparam int PRE_W      = (1 << DIV_CODE_W) - 1;
  localparam int BIT_MASK   = 16;
  localparam int BIT_PER    = 17;

  typedef enum logic [1:0] {
    ADR_CTRL = 2'd0,
    ADR_INIT = 2'd1,
    ADR_CUR  = 2'd2,
    ADR_DIV  = 2'd3
  } tmr_addr_e;

  typedef struct packed {
    logic             periodic;
    logic             masked;
    logic [VEC_W-1:0] vector;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  cur_cnt,
  output tmr_ctrl_t         ctrl_q,
  output logic [CNT_W-1:0]  init_q,
  output logic [3:0]        div_q,
  output logic              init_wr,
  output logic [DATA_W-1:0] rdata
);
  tmr_addr_e        sel;
  tmr_ctrl_t        ctrl_d;
  logic [CNT_W-1:0] init_d;
  logic [3:0]       div_d;

  assign sel     = tmr_addr_e'(addr);
  assign init_wr = wr && (sel == ADR_INIT);

  always_comb begin
    ctrl_d = ctrl_q;
    init_d = init_q;
    div_d  = div_q;
    if (wr) begin
      case (sel)
        ADR_CTRL: begin
          ctrl_d.periodic = wdata[BIT_PER];
          ctrl_d.masked   = wdata[BIT_MASK];
          ctrl_d.vector   = wdata[VEC_W-1:0];
        end
        ADR_INIT: init_d = wdata[CNT_W-1:0];
        ADR_DIV:  div_d  = wdata[3:0] & 4'b1011;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q.periodic <= 1'b0;
      ctrl_q.masked   <= 1'b1;
      ctrl_q.vector   <= '0;
      init_q          <= '0;
      div_q           <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      init_q <= init_d;
      div_q  <= div_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      ADR_CTRL: begin
        rdata[BIT_PER]    = ctrl_q.periodic;
        rdata[BIT_MASK]   = ctrl_q.masked;
        rdata[VEC_W-1:0]  = ctrl_q.vector;
      end
      ADR_INIT: rdata = DATA_W'(init_q);
      ADR_CUR:  rdata = DATA_W'(cur_cnt);
      ADR_DIV:  rdata = DATA_W'(div_q);
      default:  rdata = '0;
    endcase
  end

  assert_div_readback_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == ADR_DIV) |-> (rdata[2] == 1'b0 && rdata[DATA_W-1:4] == '0));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import timer_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       restart,
  input  logic [3:0] div_cfg,
  output logic       div_tick
);
  logic [DIV_CODE_W-1:0] code;
  logic [DIV_CODE_W-1:0] shift;
  logic [PRE_W-1:0]      mask;
  logic [PRE_W-1:0]      pre_q;
  logic [PRE_W-1:0]      pre_d;
  logic                  match;

  assign code  = {div_cfg[3], div_cfg[1:0]};
  assign shift = code + 1'b1;

  for (genvar i = 0; i < PRE_W; i++) begin : g_mask
    assign mask[i] = (shift > DIV_CODE_W'(i));
  end

  assign match    = ((pre_q & mask) == mask);
  assign div_tick = tick && !restart && match;

  always_comb begin
    pre_d = pre_q;
    if (restart)   pre_d = '0;
    else if (tick) pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assert_div_by_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !restart && code == '1) |-> div_tick);
  assert_phase_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(restart) |-> (pre_q == '0));
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             div_tick,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] init_q,
  input  logic             periodic,
  output logic [CNT_W-1:0] cnt_q,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_d;
  logic             done_q;
  logic             done_d;
  logic             at_zero;

  assign at_zero = (cnt_q == '0);
  assign expire  = div_tick && !load && at_zero && (init_q != '0) &&
                   (periodic || !done_q);

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (load) begin
      cnt_d  = load_val;
      done_d = 1'b0;
    end else if (div_tick) begin
      if (!at_zero) cnt_d = cnt_q - CNT_W'(1);
      else if (expire) begin
        if (periodic) cnt_d  = init_q;
        else          done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && cnt_q != $past(cnt_q)) |->
      (cnt_q == $past(cnt_q) - CNT_W'(1) ||
       ($past(cnt_q) == '0 && cnt_q == $past(init_q))));
  assert_oneshot_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(expire) && !$past(periodic)) |-> (cnt_q == '0 && done_q));
  assert_periodic_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(expire) && $past(periodic)) |-> (cnt_q == $past(init_q)));
  assert_zero_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q == '0 && !load) |=> !$past(expire));
endmodule

// File: rtl/prog_div_timer.sv
module prog_div_timer
  import timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              base_tick,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_valid,
  output logic [VEC_W-1:0]  irq_vector
);
  logic [1:0]       rst_sync;
  logic             rst_int_n;
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] init_val;
  logic [CNT_W-1:0] cur_cnt;
  logic [3:0]       div_cfg;
  logic             init_wr;
  logic             div_tick;
  logic             expire;
  logic             irq_d;
  logic [VEC_W-1:0] vec_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n), .wr(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .cur_cnt(cur_cnt), .ctrl_q(ctrl), .init_q(init_val),
    .div_q(div_cfg), .init_wr(init_wr), .rdata(reg_rdata)
  );

  tmr_prescale u_pre (
    .clk(clk), .rst_n(rst_int_n), .tick(base_tick), .restart(init_wr),
    .div_cfg(div_cfg), .div_tick(div_tick)
  );

  tmr_count #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .div_tick(div_tick), .load(init_wr),
    .load_val(reg_wdata[CNT_W-1:0]), .init_q(init_val),
    .periodic(ctrl.periodic), .cnt_q(cur_cnt), .expire(expire)
  );

  always_comb begin
    irq_d = expire && !ctrl.masked;
    vec_d = irq_vector;
    if (expire) vec_d = ctrl.vector;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else begin
      irq_valid  <= irq_d;
      irq_vector <= vec_d;
    end
  end

  assert_irq_unmasked_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_valid |-> !$past(ctrl.masked));
  assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_valid |=> !irq_valid);
  assert_vector_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_valid |-> (irq_vector == $past(ctrl.vector)));
endmodule

// File: tb/prog_div_timer_test.sv
module prog_div_timer_test;
  logic        clk;
  logic        rst_n;
  logic        base_tick;
  logic        reg_wr;
  logic [1:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq_valid;
  logic [7:0]  irq_vector;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  logic [31:0] last_rd;

  logic [31:0] m_ctrl, m_init, m_cnt;
  logic [3:0]  m_div;
  int unsigned m_ticks;
  bit          m_done, m_irq;
  logic [7:0]  m_vec;

  prog_div_timer uut (
    .clk(clk), .rst_n(rst_n), .base_tick(base_tick), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic int shift_of(logic [3:0] d);
    return (int'({d[3], d[1:0]}) + 1) % 8;
  endfunction

  function automatic logic [31:0] model_read(logic [1:0] a);
    case (a)
      2'd0: return m_ctrl;
      2'd1: return m_init;
      2'd2: return m_cnt;
      default: return {28'h0, m_div};
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    m_ctrl = 32'h0001_0000; m_init = 0; m_cnt = 0; m_div = 0;
    m_ticks = 0; m_done = 0; m_irq = 0; m_vec = 0;
  endtask

  task automatic model_edge(bit tk, bit wr, logic [1:0] wa, logic [31:0] wd);
    bit reload, dt, per, ex;
    int s;
    reload = wr && (wa == 2'd1);
    s  = shift_of(m_div);
    dt = tk && !reload && (((m_ticks + 1) % (32'd1 << s)) == 0);
    per = m_ctrl[17];
    ex = dt && (m_cnt == 0) && (m_init != 0) && (per || !m_done);
    m_irq = ex && !m_ctrl[16];
    if (ex) m_vec = m_ctrl[7:0];
    if (tk && !reload) m_ticks++;
    if (dt) begin
      if (m_cnt != 0) m_cnt = m_cnt - 1;
      else if (ex) begin
        if (per) m_cnt = m_init;
        else m_done = 1;
      end
    end
    if (wr) begin
      case (wa)
        2'd0: m_ctrl = wd & 32'h0003_00FF;
        2'd1: begin m_init = wd; m_cnt = wd; m_ticks = 0; m_done = 0; end
        2'd3: m_div = wd[3:0] & 4'hB;
        default: ;
      endcase
    end
  endtask

  function automatic string tag_of(logic [1:0] a);
    case (a)
      2'd0: return "R6 control";
      2'd1: return "R3 start";
      2'd2: return "R4 count";
      default: return "R1 divide";
    endcase
  endfunction

  task automatic cyc(bit tk, bit wr, logic [1:0] wa, logic [31:0] wd, logic [1:0] ra);
    base_tick = tk; reg_wr = wr; reg_wdata = wd;
    reg_addr = wr ? wa : ra;
    @(posedge clk);
    model_edge(tk, wr, wa, wd);
    @(negedge clk);
    base_tick = 0; reg_wr = 0; reg_addr = ra;
    #1;
    last_rd = reg_rdata;
    if (irq_valid) pulses++;
    check(irq_valid == m_irq, "R6 irq_valid", 32'(irq_valid), 32'(m_irq));
    if (m_irq) check(irq_vector == m_vec, "R6 vector", 32'(irq_vector), 32'(m_vec));
    check(reg_rdata == model_read(ra), tag_of(ra), reg_rdata, model_read(ra));
  endtask

  task automatic wreg(logic [1:0] a, logic [31:0] d);
    cyc(0, 1, a, d, 2'd2);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 2'd2);
  endtask

  task automatic rd(logic [1:0] a);
    cyc(0, 0, 0, 0, a);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual 0x1 expected 0x0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    base_tick = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    rst_n = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    #1;

    // R8 reset values
    rd(2'd0); check(last_rd == 32'h0001_0000, "R8 control reset", last_rd, 32'h0001_0000);
    check(irq_valid == 1'b0, "R8 irq low", 32'(irq_valid), 0);
    rd(2'd1); check(last_rd == 0, "R8 start reset", last_rd, 0);
    rd(2'd2); check(last_rd == 0, "R8 count reset", last_rd, 0);
    rd(2'd3); check(last_rd == 0, "R8 divide reset", last_rd, 0);

    // R1 write mask
    wreg(2'd3, 32'hFFFF_FFFF); rd(2'd3);
    check(last_rd == 32'hB, "R1 divide mask", last_rd, 32'hB);
    wreg(2'd3, 32'h4); rd(2'd3);
    check(last_rd == 32'h0, "R1 bit 2 dropped", last_rd, 32'h0);

    // R10 count address ignores writes, reads have no side effect
    wreg(2'd2, 32'h55); rd(2'd2); rd(2'd2);
    check(last_rd == 0, "R10 count write ignored", last_rd, 0);

    // R4 one-shot, divide by one
    wreg(2'd3, 32'hB);
    wreg(2'd0, 32'h0000_0042);
    wreg(2'd1, 3);
    pulses = 0;
    run(12);
    check(pulses == 1, "R4 single expiry", pulses, 1);
    check(last_rd == 0, "R4 holds at zero", last_rd, 0);

    // R7 finished one-shot switched to periodic
    pulses = 0;
    wreg(2'd1, 2); run(10);
    check(pulses == 1, "R7 one-shot before switch", pulses, 1);
    pulses = 0;
    wreg(2'd0, 32'h0002_0011); run(9);
    check(pulses == 3, "R7 periodic after switch", pulses, 3);

    // R5 periodic, shift 1
    wreg(2'd3, 32'h0);
    wreg(2'd0, 32'h0002_0055);
    pulses = 0;
    wreg(2'd1, 2); run(48);
    check(pulses == 8, "R5 periodic expiry count", pulses, 8);

    // R6 masked expiries are dropped while counting goes on
    wreg(2'd3, 32'hB);
    wreg(2'd0, 32'h0003_0077);
    pulses = 0;
    wreg(2'd1, 1); run(20);
    check(pulses == 0, "R6 masked no request", pulses, 0);
    rd(2'd0); check(last_rd == 32'h0003_0077, "R6 control read", last_rd, 32'h0003_0077);

    // R9 zero start value
    wreg(2'd0, 32'h0000_0099);
    pulses = 0;
    wreg(2'd1, 0); run(20);
    wreg(2'd0, 32'h0002_0099); run(20);
    check(pulses == 0, "R9 no expiry at zero", pulses, 0);
    check(last_rd == 0, "R9 count zero", last_rd, 0);

    // R3 phase restart, divide by 8 (code 2)
    wreg(2'd3, 32'h2);
    wreg(2'd1, 5); run(5);
    wreg(2'd1, 5); run(7);
    check(last_rd == 5, "R3 phase restarted", last_rd, 5);
    run(1);
    check(last_rd == 4, "R3 first step after 8", last_rd, 4);

    // R2 code 6 divides by 128
    wreg(2'd3, 32'hA);
    wreg(2'd1, 9); run(127);
    check(last_rd == 9, "R2 no step before 128", last_rd, 9);
    run(1);
    check(last_rd == 8, "R2 step at 128", last_rd, 8);

    // Random phase
    void'($urandom(32'd20240611));
    for (int i = 0; i < 4000; i++) begin
      int r;
      bit tk;
      logic [1:0] ra;
      r  = $urandom_range(0, 99);
      tk = ($urandom_range(0, 9) < 7);
      ra = 2'($urandom_range(0, 3));
      if (r < 4) begin
        logic [31:0] d;
        d = $urandom;
        d[16] = ($urandom_range(0, 3) == 0);
        cyc(tk, 1, 2'd0, d, ra);
      end else if (r < 7) begin
        logic [31:0] d;
        d = ($urandom_range(0, 9) == 0) ? 0 : 32'($urandom_range(1, 15));
        cyc(tk, 1, 2'd1, d, ra);
      end else if (r < 9) begin
        logic [31:0] d;
        d = $urandom;
        if ($urandom_range(0, 1) == 0) d[3:0] = {d[3], 1'b0, 2'b11};
        cyc(tk, 1, 2'd3, d, ra);
      end else if (r < 10) begin
        cyc(tk, 1, 2'd2, $urandom, ra);
      end else begin
        cyc(tk, 0, 0, 0, ra);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule